// File: doc/BRIEF.md
# Interrupt Acknowledge Cascade Encoder

This block sits beside a processor bus that services interrupts from a master interrupt controller with slave controllers cascaded below it. The processor answers each interrupt with two acknowledge bus cycles in a row. In the first cycle the master puts an 8-bit cascade address on the data bus. The block captures that byte when the cycle ends, and the end of a cycle is marked by the master pulling its active-low ready line while the acknowledge cycle is in progress.

From the end of the first cycle until the end of the second, the block drives the low bits of the captured address onto three shared, active-low slave-select lines. The selected slave can then place its vector on the bus during the second cycle. The value stays put through the idle bus states between the two cycles. The block also reports which side owns the data bus in the current acknowledge phase. It counts completed acknowledge cycles and shows whether the next cycle will be the second one of a pair.

A cascade-enable input, sampled at the end of the first cycle, says whether the pending request belongs to a slave. If it does not, the select lines stay high and the master keeps the bus for the second cycle.

Top module: `inta_cascade_enc`

## Requirements
- R1: A synchronous reset (rst_i high at a clock edge) sets cas_n_o to all ones, second_o to 0 and ack_cnt_o to 0. It also clears any half-finished acknowledge pair.
- R2: An acknowledge cycle ends at a rising clock edge where inta_i is 1 and ready_n_i is 0. Edges with ready_n_i high, which are wait states, neither advance the phase nor change ack_cnt_o.
- R3: When a first cycle ends with casc_en_i at 1, cas_n_o equals the bitwise inverse of data_i[2:0] sampled at that edge, from the following clock onward. second_o then reads 1.
- R4: Between the end of the first cycle and the end of the second, cas_n_o holds its value whatever data_i and casc_en_i do.
- R5: During a second cycle of a cascaded pair, slave_own_o is 1 and master_own_o is 0.
- R6: When a first cycle ends with casc_en_i at 0, cas_n_o stays at all ones through the pair. In the second cycle master_own_o is 1 and slave_own_o is 0.
- R7: After the second cycle ends, cas_n_o returns to all ones and second_o returns to 0.
- R8: ack_cnt_o increases by one at every cycle end and wraps modulo 2^CNT_W.
- R9: During a first cycle master_own_o is 1 and slave_own_o is 0. With inta_i low, both are 0.
- R10: Bits 7:3 of the captured address have no effect on cas_n_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| inta_i | input | 1 | Processor is running an interrupt-acknowledge bus cycle |
| ready_n_i | input | 1 | Active-low ready from the master; low ends the cycle |
| data_i | input | ADDR_W | Data bus as seen during acknowledge cycles |
| casc_en_i | input | 1 | Pending request is served by a slave |
| cas_n_o | output | CAS_W | Active-low encoded slave select lines |
| slave_own_o | output | 1 | A slave drives the data bus in this cycle |
| master_own_o | output | 1 | The master drives the data bus in this cycle |
| second_o | output | 1 | Next or current acknowledge cycle is the second of the pair |
| ack_cnt_o | output | CNT_W | Count of completed acknowledge cycles |

## Verification
The hardest situation to reach is one where the select lines must hold through the idle gap and the second cycle while the data bus and the cascade-enable input change under them. Only a correct phase toggle keeps them steady. The stimulus sweeps every one of the 256 address bytes through complete acknowledge pairs with five wait states each. It drives inverted and scrambled values onto the bus during the four idle states and the second cycle. Cascaded and non-cascaded requests are interleaved, and the run is long enough to wrap the cycle counter. A reset issued between the two cycles of a pair checks that the half-finished pair is dropped.

// File: rtl/inta_cas_pkg.sv
package inta_cas_pkg;

  localparam int unsigned MAX_W = 16;

  typedef enum logic {
    PH_FIRST  = 1'b0,
    PH_SECOND = 1'b1
  } ack_phase_e;

  // Active-low select pattern: inverted address when active, all ones otherwise.
  function automatic logic [MAX_W-1:0] cas_pattern(input logic [MAX_W-1:0] addr,
                                                   input logic active);
    return active ? ~addr : {MAX_W{1'b1}};
  endfunction

  function automatic ack_phase_e next_phase(input ack_phase_e cur);
    return (cur == PH_FIRST) ? PH_SECOND : PH_FIRST;
  endfunction

endpackage

// File: rtl/inta_phase_track.sv
module inta_phase_track
  import inta_cas_pkg::*;
(
  input  logic       clk,
  input  logic       rst_i,
  input  logic       inta_i,
  input  logic       ready_n_i,
  output logic       cyc_end_o,
  output logic       first_end_o,
  output logic       second_end_o,
  output ack_phase_e phase_o
);

  ack_phase_e phase_q;

  assign cyc_end_o    = inta_i & ~ready_n_i;
  assign first_end_o  = cyc_end_o & (phase_q == PH_FIRST);
  assign second_end_o = cyc_end_o & (phase_q == PH_SECOND);
  assign phase_o      = phase_q;

  always_ff @(posedge clk) begin
    if (rst_i)          phase_q <= PH_FIRST;
    else if (cyc_end_o) phase_q <= next_phase(phase_q);
  end

endmodule

// File: rtl/inta_addr_latch.sv
module inta_addr_latch #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_i,
  input  logic              load_i,
  input  logic              clear_i,
  input  logic [ADDR_W-1:0] data_i,
  input  logic              casc_en_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              casc_o
);

  logic [ADDR_W-1:0] addr_q;
  logic              casc_q;

  always_ff @(posedge clk) begin
    if (rst_i) begin
      addr_q <= '0;
      casc_q <= 1'b0;
    end else if (load_i) begin
      addr_q <= data_i;
      casc_q <= casc_en_i;
    end else if (clear_i) begin
      casc_q <= 1'b0;
    end
  end

  assign addr_o = addr_q;
  assign casc_o = casc_q;

endmodule

// File: rtl/inta_ack_counter.sv
module inta_ack_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst_i)      cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/inta_cascade_enc.sv
module inta_cascade_enc
  import inta_cas_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CAS_W  = 3,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_i,
  input  logic              inta_i,
  input  logic              ready_n_i,
  input  logic [ADDR_W-1:0] data_i,
  input  logic              casc_en_i,
  output logic [CAS_W-1:0]  cas_n_o,
  output logic              slave_own_o,
  output logic              master_own_o,
  output logic              second_o,
  output logic [CNT_W-1:0]  ack_cnt_o
);

  localparam int unsigned EXT_W = MAX_W;

  // Named internal events, visible to the bound checker.
  logic              cyc_end;
  logic              first_end;
  logic              second_end;
  ack_phase_e        phase;
  logic [ADDR_W-1:0] addr_q;
  logic              casc_q;
  logic              cas_active;
  logic [EXT_W-1:0]  addr_ext;
  logic [EXT_W-1:0]  cas_ext;

  inta_phase_track u_phase (
    .clk          (clk),
    .rst_i        (rst_i),
    .inta_i       (inta_i),
    .ready_n_i    (ready_n_i),
    .cyc_end_o    (cyc_end),
    .first_end_o  (first_end),
    .second_end_o (second_end),
    .phase_o      (phase)
  );

  inta_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk       (clk),
    .rst_i     (rst_i),
    .load_i    (first_end),
    .clear_i   (second_end),
    .data_i    (data_i),
    .casc_en_i (casc_en_i),
    .addr_o    (addr_q),
    .casc_o    (casc_q)
  );

  inta_ack_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_i (rst_i),
    .inc_i (cyc_end),
    .cnt_o (ack_cnt_o)
  );

  assign cas_active = (phase == PH_SECOND) & casc_q;

  always_comb begin
    addr_ext = '0;
    addr_ext[ADDR_W-1:0] = addr_q;
  end

  assign cas_ext = cas_pattern(addr_ext, cas_active);

  for (genvar gi = 0; gi < CAS_W; gi++) begin : g_cas
    assign cas_n_o[gi] = cas_ext[gi];
  end

  assign slave_own_o  = inta_i & cas_active;
  assign master_own_o = inta_i & ~cas_active;
  assign second_o     = (phase == PH_SECOND);

endmodule

// File: rtl/inta_cascade_chk.sv
module inta_cascade_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CAS_W  = 3,
  parameter int unsigned CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_i,
  input logic [ADDR_W-1:0] data_i,
  input logic              casc_en_i,
  input logic              inta_i,
  input logic [CAS_W-1:0]  cas_n_o,
  input logic              slave_own_o,
  input logic              master_own_o,
  input logic              second_o,
  input logic [CNT_W-1:0]  ack_cnt_o,
  input logic              cyc_end
);

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst_i |=> (cas_n_o == '1) && !second_o && (ack_cnt_o == '0)); // R1

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst_i)
    !cyc_end |=> $stable(ack_cnt_o) && $stable(second_o)); // R2

  AST_LATCH_ADDR: assert property (@(posedge clk) disable iff (rst_i)
    (cyc_end && !second_o && casc_en_i) |=>
      (cas_n_o == ~$past(data_i[CAS_W-1:0])) && second_o); // R3

  AST_CAS_STABLE: assert property (@(posedge clk) disable iff (rst_i)
    (second_o && !cyc_end) |=> $stable(cas_n_o)); // R4

  AST_OWN_EXCL: assert property (@(posedge clk) disable iff (rst_i)
    !(slave_own_o && master_own_o)); // R5

  AST_NO_CASC: assert property (@(posedge clk) disable iff (rst_i)
    (cyc_end && !second_o && !casc_en_i) |=> (cas_n_o == '1)); // R6

  AST_RELEASE: assert property (@(posedge clk) disable iff (rst_i)
    (cyc_end && second_o) |=> (cas_n_o == '1) && !second_o); // R7

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst_i)
    cyc_end |=> ack_cnt_o == $past(ack_cnt_o) + 1'b1); // R8

  AST_IDLE_OWN: assert property (@(posedge clk) disable iff (rst_i)
    !inta_i |-> !slave_own_o && !master_own_o); // R9

  AST_FIRST_MASTER: assert property (@(posedge clk) disable iff (rst_i)
    (inta_i && !second_o) |-> master_own_o); // R9

endmodule

bind inta_cascade_enc inta_cascade_chk #(
  .ADDR_W (ADDR_W),
  .CAS_W  (CAS_W),
  .CNT_W  (CNT_W)
) chk_i (
  .clk          (clk),
  .rst_i        (rst_i),
  .data_i       (data_i),
  .casc_en_i    (casc_en_i),
  .inta_i       (inta_i),
  .cas_n_o      (cas_n_o),
  .slave_own_o  (slave_own_o),
  .master_own_o (master_own_o),
  .second_o     (second_o),
  .ack_cnt_o    (ack_cnt_o),
  .cyc_end      (cyc_end)
);

// File: tb/inta_cascade_enc_tb.sv
`timescale 1ns/1ps
module inta_cascade_enc_tb_top;

  logic       clk = 1'b0;
  logic       rst_i = 1'b1;
  logic       inta_i = 1'b0;
  logic       ready_n_i = 1'b1;
  logic [7:0] data_i = 8'h00;
  logic       casc_en_i = 1'b0;
  logic [2:0] cas_n_o;
  logic       slave_own_o;
  logic       master_own_o;
  logic       second_o;
  logic [7:0] ack_cnt_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_cnt = 8'd0;

  always #4 clk = ~clk;

  inta_cascade_enc #(.ADDR_W(8), .CAS_W(3), .CNT_W(8)) dut_i (
    .clk          (clk),
    .rst_i        (rst_i),
    .inta_i       (inta_i),
    .ready_n_i    (ready_n_i),
    .data_i       (data_i),
    .casc_en_i    (casc_en_i),
    .cas_n_o      (cas_n_o),
    .slave_own_o  (slave_own_o),
    .master_own_o (master_own_o),
    .second_o     (second_o),
    .ack_cnt_o    (ack_cnt_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Select value from the requirements: inverse of the low three address bits when cascaded.
  function automatic logic [2:0] exp_sel(input logic [7:0] a, input logic c);
    logic [2:0] v;
    v = 3'b111 - a[2:0];
    return c ? v : 3'b111;
  endfunction

  // Called at a falling edge; runs one acknowledge cycle with five wait states.
  task automatic ack_cycle(input logic [7:0] d, input logic ce,
                           input logic exp_slave, input logic [2:0] exp_cas,
                           input string req);
    inta_i = 1'b1; ready_n_i = 1'b1; data_i = d; casc_en_i = ce;
    repeat (5) @(negedge clk);
    chk({req, " slave_own"}, slave_own_o, exp_slave);
    chk({req, " master_own"}, master_own_o, !exp_slave);
    chk({req, " cas in cycle"}, cas_n_o, exp_cas);
    chk("R2 count held in wait states", ack_cnt_o, exp_cnt);
    ready_n_i = 1'b0;
    @(negedge clk);
    exp_cnt = exp_cnt + 8'd1;
    inta_i = 1'b0; ready_n_i = 1'b1;
  endtask

  task automatic run_pair(input logic [7:0] a, input logic c);
    logic [2:0] sel;
    sel = exp_sel(a, c);
    ack_cycle(a, c, 1'b0, 3'b111, "R9 first cycle");
    chk("R3 second_o after first end", second_o, 1);
    chk(c ? "R3 R10 cas after latch" : "R6 cas stays high", cas_n_o, sel);
    chk("R8 count after first", ack_cnt_o, exp_cnt);
    for (int k = 0; k < 4; k++) begin
      data_i = ~a ^ 8'(k); casc_en_i = ~c;
      @(negedge clk);
      chk("R4 cas stable in idle", cas_n_o, sel);
      chk("R9 no owner in idle", {slave_own_o, master_own_o}, 0);
    end
    ack_cycle(a ^ 8'hA5, ~c, c, sel, c ? "R5 second cycle" : "R6 second cycle");
    chk("R7 cas released", cas_n_o, 7);
    chk("R7 phase back to first", second_o, 0);
    chk("R8 count after second", ack_cnt_o, exp_cnt);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 cas after reset", cas_n_o, 7);
    chk("R1 phase after reset", second_o, 0);
    chk("R1 count after reset", ack_cnt_o, 0);
    chk("R1 no owner after reset", {slave_own_o, master_own_o}, 0);
    rst_i = 1'b0;
    @(negedge clk);
    for (int n = 0; n < 256; n++) begin
      run_pair(8'(n), (n % 3) != 0);
      @(negedge clk);
    end
    chk("R8 count wrapped", ack_cnt_o, 0);
    // Reset between the two cycles of a pair.
    ack_cycle(8'h05, 1'b1, 1'b0, 3'b111, "R9 first cycle");
    chk("R3 cas before reset", cas_n_o, 2);
    rst_i = 1'b1;
    @(negedge clk);
    rst_i = 1'b0;
    exp_cnt = 8'd0;
    chk("R1 cas after mid-pair reset", cas_n_o, 7);
    chk("R1 phase after mid-pair reset", second_o, 0);
    chk("R1 count after mid-pair reset", ack_cnt_o, 0);
    run_pair(8'hFB, 1'b1);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule